// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit moves the elements of one vector into a destination vector under control of a per-element mask. Each element of the vector has one mask bit. The unit has four operations. Pack gathers the selected source elements into the low end of the destination. Spread scatters consecutive source elements out to the selected positions. Merge writes each selected source element to its own position. Fill writes every position.

A request is accepted on a start pulse, and all operands are captured at that moment. The unit then walks the vector one element per cycle. For each element it presents at most one write (enable, index, data) to the destination register file. A position that receives no write keeps its old contents, so the unit never needs to read the destination. The write position comes from a running tally of the mask bits already seen. Elements whose bit is clear are either skipped or suppressed. A done pulse marks the cycle of the last element. The number of selected elements is presented on a count output.

Top module: `vmask_pack_unit`

## Requirements
- R1: After reset, wr_en_o, done_o and busy_o are 0 and count_o is 0.
- R2: Pack (op_i = 1). For every element i below the vector length whose mask bit is 1, the unit writes src element i to destination index k, where k is the number of mask bits set below i. These writes are issued in increasing i. No other writes are issued.
- R3: count_o equals the number of qualifying mask bits below the vector length (for fill, the vector length). It is valid from the first element cycle and is held until the next accepted start.
- R4: Spread (op_i = 2). For each element i below the vector length whose mask bit is 1, the unit writes src element k to destination index i, where k is the number of mask bits set below i. Positions whose bit is 0 are not written.
- R5: Merge (op_i = 0). For each element i below the vector length whose mask bit is 1, the unit writes src element i to index i. Positions whose bit is 0 are not written.
- R6: Fill (op_i = 3). Every element i below the vector length is written with src element i, whatever the mask holds.
- R7: Mask bits at or beyond the vector length have no effect. A vl_i larger than the element count is treated as the element count.
- R8: The first element is handled in the cycle after start is accepted, and one element is handled per cycle. done_o pulses for one cycle, in the cycle of element vl-1. With a length of 0 there is one busy cycle with done_o high and no write.
- R9: A start pulse while busy_o is 1 is ignored. The running operation, its writes and its count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, accepted when idle |
| op_i | input | 2 | 0 merge, 1 pack, 2 spread, 3 fill |
| vl_i | input | VLW | Vector length |
| mask_i | input | NELEM | One mask bit per element |
| src_i | input | NELEM*DW | Source vector, element i at bits i*DW +: DW |
| busy_o | output | 1 | Operation in progress |
| wr_en_o | output | 1 | Destination write enable this cycle |
| wr_idx_o | output | IW | Destination element index |
| wr_data_o | output | DW | Destination write data |
| done_o | output | 1 | Pulse in the last element cycle |
| count_o | output | VLW | Number of selected elements |

## Verification
On every cycle, the assertions check four things. Writes occur only while busy. The running tally never passes the element index. Pack never writes ahead of the element being read. The tally at done agrees with the separately computed count. They also check that done ends the operation and that a start arriving mid-operation leaves the captured length alone. Only the bench's scenarios can show that the exact sequence of indices and data matches each operation, that unwritten positions stay untouched, and that masks, lengths of zero and oversized lengths are handled correctly.

// File: rtl/vmc_pkg.sv
package vmc_pkg;
  typedef enum logic [1:0] {
    VOP_MERGE  = 2'd0,
    VOP_PACK   = 2'd1,
    VOP_SPREAD = 2'd2,
    VOP_FILL   = 2'd3
  } vop_e;
endpackage

// File: rtl/vmc_rst_sync.sv
module vmc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/vmc_mask_qual.sv
module vmc_mask_qual
  import vmc_pkg::*;
#(
  parameter int NELEM = 16,
  parameter int VLW   = $clog2(NELEM + 1)
) (
  input  logic [NELEM-1:0] mask_i,
  input  logic [VLW-1:0]   vl_i,
  input  vop_e             op_i,
  output logic [NELEM-1:0] qmask_o,
  output logic [VLW-1:0]   count_o
);
  // Per-element qualification: inside the length, and either selected or filled.
  for (genvar g = 0; g < NELEM; g++) begin : g_bit
    assign qmask_o[g] = (VLW'(g) < vl_i) && ((op_i == VOP_FILL) || mask_i[g]);
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < NELEM; i++) begin
      count_o = count_o + VLW'(qmask_o[i]);
    end
  end
endmodule

// File: rtl/vmc_ctrl.sv
module vmc_ctrl #(
  parameter int NELEM = 16,
  parameter int VLW   = $clog2(NELEM + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           elem_sel_i,
  output logic           accept_o,
  output logic           busy_o,
  output logic           active_o,
  output logic [VLW-1:0] idx_o,
  output logic [VLW-1:0] tally_o,
  output logic           done_o
);
  logic           busy_q, busy_d;
  logic [VLW-1:0] idx_q, idx_d;
  logic [VLW-1:0] tally_q, tally_d;
  logic [VLW-1:0] vl_q;
  logic [VLW-1:0] last_idx;
  logic           last_c;

  assign accept_o = start_i && !busy_q;
  assign last_idx = (vl_q == '0) ? '0 : vl_q - VLW'(1);
  assign last_c   = busy_q && (idx_q == last_idx);
  assign active_o = busy_q && (idx_q < vl_q);

  always_comb begin
    busy_d  = busy_q;
    idx_d   = idx_q;
    tally_d = tally_q;
    if (accept_o) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      tally_d = '0;
    end else if (busy_q) begin
      if (last_c) busy_d = 1'b0;
      idx_d = idx_q + VLW'(1);
      if (active_o && elem_sel_i) tally_d = tally_q + VLW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      tally_q <= '0;
      vl_q    <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      tally_q <= tally_d;
      if (accept_o) vl_q <= vl_i;
    end
  end

  assign busy_o  = busy_q;
  assign idx_o   = idx_q;
  assign tally_o = tally_q;
  assign done_o  = last_c;

  p_tally_le_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tally_q <= idx_q));
  p_done_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !busy_q);
  p_start_busy_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i |=> $stable(vl_q));
endmodule

// File: rtl/vmc_route.sv
module vmc_route
  import vmc_pkg::*;
#(
  parameter int NELEM = 16,
  parameter int DW    = 32,
  parameter int VLW   = $clog2(NELEM + 1),
  parameter int IW    = $clog2(NELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NELEM*DW-1:0] src_i,
  input  vop_e                op_i,
  input  logic                active_i,
  input  logic                sel_i,
  input  logic [VLW-1:0]      idx_i,
  input  logic [VLW-1:0]      tally_i,
  output logic                wr_en_o,
  output logic [IW-1:0]       wr_idx_o,
  output logic [DW-1:0]       wr_data_o
);
  logic [IW-1:0] rd_sel;
  logic [IW-1:0] idx_n, tally_n;
  logic [DW-1:0] elem [NELEM];

  for (genvar g = 0; g < NELEM; g++) begin : g_elem
    assign elem[g] = src_i[g*DW +: DW];
  end

  assign idx_n   = idx_i[IW-1:0];
  assign tally_n = tally_i[IW-1:0];

  always_comb begin
    wr_en_o  = active_i && sel_i;
    wr_idx_o = idx_n;
    rd_sel   = idx_n;
    unique case (op_i)
      VOP_PACK:   wr_idx_o = tally_n;
      VOP_SPREAD: rd_sel   = tally_n;
      default:    ;
    endcase
    wr_data_o = elem[rd_sel];
  end

  p_pack_no_ahead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && (op_i == VOP_PACK) |-> (VLW'(wr_idx_o) <= idx_i));
endmodule

// File: rtl/vmask_pack_unit.sv
module vmask_pack_unit
  import vmc_pkg::*;
#(
  parameter int NELEM = 16,
  parameter int DW    = 32,
  parameter int VLW   = $clog2(NELEM + 1),
  parameter int IW    = $clog2(NELEM)
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [VLW-1:0]      vl_i,
  input  logic [NELEM-1:0]    mask_i,
  input  logic [NELEM*DW-1:0] src_i,
  output logic                busy_o,
  output logic                wr_en_o,
  output logic [IW-1:0]       wr_idx_o,
  output logic [DW-1:0]       wr_data_o,
  output logic                done_o,
  output logic [VLW-1:0]      count_o
);
  logic                rst_n;
  logic [VLW-1:0]      vl_eff;
  logic [NELEM-1:0]    qmask_c;
  logic [VLW-1:0]      cnt_c;
  logic                accept;
  logic                active;
  logic [VLW-1:0]      idx, tally;
  logic                cur_sel;

  logic [NELEM*DW-1:0] src_q;
  logic [NELEM-1:0]    qmask_q;
  vop_e                op_q;
  logic [VLW-1:0]      cnt_q;

  vmc_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rst_n));

  assign vl_eff = (vl_i > VLW'(NELEM)) ? VLW'(NELEM) : vl_i;

  vmc_mask_qual #(.NELEM(NELEM), .VLW(VLW)) u_qual (
    .mask_i (mask_i),
    .vl_i   (vl_eff),
    .op_i   (vop_e'(op_i)),
    .qmask_o(qmask_c),
    .count_o(cnt_c)
  );

  assign cur_sel = qmask_q[idx[IW-1:0]];

  vmc_ctrl #(.NELEM(NELEM), .VLW(VLW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .vl_i      (vl_eff),
    .elem_sel_i(cur_sel),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .active_o  (active),
    .idx_o     (idx),
    .tally_o   (tally),
    .done_o    (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      qmask_q <= '0;
      op_q    <= VOP_MERGE;
      cnt_q   <= '0;
    end else if (accept) begin
      src_q   <= src_i;
      qmask_q <= qmask_c;
      op_q    <= vop_e'(op_i);
      cnt_q   <= cnt_c;
    end
  end

  vmc_route #(.NELEM(NELEM), .DW(DW), .VLW(VLW), .IW(IW)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_q),
    .op_i     (op_q),
    .active_i (active),
    .sel_i    (cur_sel),
    .idx_i    (idx),
    .tally_i  (tally),
    .wr_en_o  (wr_en_o),
    .wr_idx_o (wr_idx_o),
    .wr_data_o(wr_data_o)
  );

  assign count_o = cnt_q;

  p_write_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o);
  p_tally_matches_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((tally + VLW'(active && cur_sel)) == count_o));
endmodule

// File: tb/sim_vmask_pack_unit.sv
module sim_vmask_pack_unit;
  localparam int N   = 16;
  localparam int DW  = 32;
  localparam int VLW = $clog2(N + 1);
  localparam int IW  = $clog2(N);

  logic             clk = 1'b0;
  logic             arst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [1:0]       op_i = '0;
  logic [VLW-1:0]   vl_i = '0;
  logic [N-1:0]     mask_i = '0;
  logic [N*DW-1:0]  src_i = '0;
  logic             busy_o, wr_en_o, done_o;
  logic [IW-1:0]    wr_idx_o;
  logic [DW-1:0]    wr_data_o;
  logic [VLW-1:0]   count_o;

  always #2 clk = ~clk;

  vmask_pack_unit u0 (
    .clk(clk), .arst_n(arst_n), .start_i(start_i), .op_i(op_i), .vl_i(vl_i),
    .mask_i(mask_i), .src_i(src_i), .busy_o(busy_o), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .done_o(done_o), .count_o(count_o)
  );

  int checks = 0;
  int fails  = 0;
  logic [IW+DW-1:0] exp_q[$];
  int exp_cnt = 0;
  int exp_cycles = 0;
  string cur_req = "R2";
  bit done_seen = 0;
  bit mon_on = 0;
  int busy_cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: compares writes and completion against the scoreboard.
  always @(negedge clk) begin
    if (mon_on) begin
      if (busy_o) busy_cyc++;
      if (wr_en_o) begin
        if (exp_q.size() == 0) chk(0, cur_req, {wr_idx_o, wr_data_o}, 0);
        else begin
          logic [IW+DW-1:0] e;
          e = exp_q.pop_front();
          chk({wr_idx_o, wr_data_o} == e, cur_req, {wr_idx_o, wr_data_o}, e);
        end
      end
      if (done_o) begin
        chk(exp_q.size() == 0, {cur_req, " missing writes"}, exp_q.size(), 0);
        chk(count_o == VLW'(exp_cnt), "R3", count_o, exp_cnt);
        chk(busy_cyc == exp_cycles, "R8", busy_cyc, exp_cycles);
        busy_cyc = 0;
        done_seen = 1;
      end
    end
  end

  function automatic logic [N*DW-1:0] mk_src(input int seed);
    logic [N*DW-1:0] s;
    for (int i = 0; i < N; i++) s[i*DW +: DW] = 32'hA000_0000 + seed * 256 + i;
    return s;
  endfunction

  task automatic run_op(input string req, input logic [1:0] op, input int vl,
                        input logic [N-1:0] mask, input int seed, input bit intrude);
    logic [N*DW-1:0] s;
    int ve, k;
    s = mk_src(seed);
    ve = (vl > N) ? N : vl;
    k = 0;
    cur_req = req;
    for (int i = 0; i < ve; i++) begin
      bit sel;
      sel = (op == 2'd3) || mask[i];
      if (sel) begin
        case (op)
          2'd1:    exp_q.push_back({IW'(k), s[i*DW +: DW]});
          2'd2:    exp_q.push_back({IW'(i), s[k*DW +: DW]});
          default: exp_q.push_back({IW'(i), s[i*DW +: DW]});
        endcase
        k++;
      end
    end
    exp_cnt = k;
    exp_cycles = (ve == 0) ? 1 : ve;
    done_seen = 0;
    @(negedge clk);
    start_i = 1'b1; op_i = op; vl_i = VLW'(vl); mask_i = mask; src_i = s;
    @(negedge clk);
    start_i = 1'b0;
    chk(count_o == VLW'(exp_cnt), "R3", count_o, exp_cnt);
    if (intrude && !done_seen) begin
      start_i = 1'b1; op_i = 2'd3; vl_i = VLW'(N); mask_i = '1; src_i = mk_src(99);
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    chk(!busy_o && !wr_en_o && !done_o, "R8", {busy_o, wr_en_o, done_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!wr_en_o && !done_o && !busy_o && count_o == 0, "R1",
        {wr_en_o, done_o, busy_o, count_o}, 0);
    mon_on = 1;
    run_op("R2", 2'd1, 16, 16'hA5C3, 1, 0);
    run_op("R2", 2'd1, 16, 16'h8001, 2, 0);
    run_op("R2", 2'd1, 16, 16'hFFFF, 3, 0);
    run_op("R4", 2'd2, 16, 16'h3C5A, 4, 0);
    run_op("R4", 2'd2, 12, 16'h0F0F, 5, 0);
    run_op("R5", 2'd0, 16, 16'h1234, 6, 0);
    run_op("R5", 2'd0, 16, 16'h0000, 7, 0);
    run_op("R6", 2'd3, 10, 16'h0000, 8, 0);
    run_op("R7", 2'd1, 5,  16'hFFE0, 9, 0);
    run_op("R7", 2'd0, 25, 16'hF00F, 10, 0);
    run_op("R8", 2'd2, 0,  16'hFFFF, 11, 0);
    run_op("R8", 2'd1, 1,  16'h0001, 12, 0);
    run_op("R9", 2'd1, 9,  16'h0155, 13, 1);
    run_op("R9", 2'd2, 16, 16'h6666, 14, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule